// File: doc/BRIEF.md
# Reset Cause and Strap Capture Unit

This block merges three reset requests into a single chip-wide active-low reset: an asynchronous active-low external reset pin, a one-cycle watchdog expiry pulse and a one-cycle software reset pulse. The chip reset is held for a fixed number of clocks after the last request goes away, so every peripheral sees a full reset. The block keeps a one-hot record of which request caused the most recent reset. It also produces the reset value of the watchdog control register, which differs after a watchdog reset.

Two strap pins are sampled in the clock cycle in which the synchronized external reset is released. The first selects where code comes from: all external, or internal first. The second sets the default external data bus width. The second strap produces the reset value of the bus configuration register. After the chip reset ends, the code-select strap pin becomes the bus wait input. A power-on reset on `rst_ni` behaves like an external reset that is released once the synchronizer has filled.

Top module: `rst_cause_unit`

## Requirements
- R1: `chip_rst_no` goes low for every cause. It is low in the cycle after a sampled `wdt_trip_i` or `sw_rst_i` pulse. It is low three clock edges after `ext_rst_ni` falls, because two of those edges are synchronizer stages.
- R2: `chip_rst_no` stays low for HOLD_CYC clock edges after the last edge at which any request was seen, and then rises. An external request is seen for two edges after the pin is released.
- R3: `rst_src_o` is one-hot with bit 0 = external, bit 1 = watchdog, bit 2 = software. It keeps its value until the next reset request.
- R4: When several requests are seen in the same cycle, the recorded cause follows the priority external, then watchdog, then software.
- R5: `wdt_ctl_o` becomes 0xE6 after a reset whose recorded cause is the watchdog, and 0xE4 after any other reset.
- R6: The code-select strap is latched when the external reset is released. `code_ext_only_o` is the inverse of the latched value: 1 means all code fetches go to external memory.
- R7: `bus_cfg_o` equals binary 00000a11, where a is the latched bus-width strap.
- R8: Strap pins are ignored at all other times, including during watchdog and software resets. The latched values then do not change.
- R9: `wait_o` follows the code-select/wait pin while `chip_rst_no` is high, and is 0 while the chip is in reset.
- R10: While `rst_ni` is low, the outputs are: `chip_rst_no`=0, `rst_src_o`=001, `wdt_ctl_o`=0xE4, `bus_cfg_o`=0x07 and `code_ext_only_o`=0. When `rst_ni` is released, the straps are captured as for an external release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wdt_trip_i | input | 1 | Watchdog expiry pulse |
| sw_rst_i | input | 1 | Software reset pulse |
| code_sel_wait_i | input | 1 | Code-select strap; wait input after reset |
| bus_width_i | input | 1 | Bus-width strap |
| chip_rst_no | output | 1 | Chip-wide reset, active low |
| rst_src_o | output | 3 | One-hot cause of the last reset |
| wdt_ctl_o | output | 8 | Watchdog control register reset value |
| bus_cfg_o | output | 8 | Bus configuration register reset value |
| code_ext_only_o | output | 1 | 1 when all code fetches go to external memory |
| wait_o | output | 1 | Bus wait request |

## Verification
The hardest case to create is a set of requests that overlap inside the same sampling cycle. The external request reaches the cause logic only after the synchronizer delay, so a pulse from the pin side cannot simply be lined up with a watchdog or software pulse. The bench first holds the external pin low until the request is known to be visible. It then fires the watchdog and software pulses into that window, alone and together, and checks the recorded cause. The bench also inverts both strap pins before every watchdog and software reset. A capture at the wrong time would then show up on the bus configuration and code-select outputs.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int SRC_N   = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_SW  = 2;
  localparam logic [7:0] WDT_CTL_AFTER_WDT   = 8'hE6;
  localparam logic [7:0] WDT_CTL_AFTER_OTHER = 8'hE4;
  localparam logic [4:0] BUS_CFG_HI = 5'b00000;
  localparam logic [1:0] BUS_CFG_LO = 2'b11;
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rcu_prio.sv
module rcu_prio
  import rcu_pkg::*;
(
  input  logic [SRC_N-1:0] req_i,
  output logic             valid_o,
  output logic [SRC_N-1:0] onehot_o
);
  // lowest index wins
  always_comb begin
    onehot_o = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(HOLD_CYC);
    else if (req_i)        cnt_q <= CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcu_pkg::*;
#(
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       wdt_trip_i,
  input  logic       sw_rst_i,
  input  logic       code_sel_wait_i,
  input  logic       bus_width_i,
  output logic       chip_rst_no,
  output logic [2:0] rst_src_o,
  output logic [7:0] wdt_ctl_o,
  output logic [7:0] bus_cfg_o,
  output logic       code_ext_only_o,
  output logic       wait_o
);
  logic             ext_n_sync;
  logic             ext_req;
  logic             ext_req_q;
  logic             strap_cap;
  logic [SRC_N-1:0] req;
  logic [SRC_N-1:0] req_onehot;
  logic             req_any;
  logic             rst_active;
  logic [SRC_N-1:0] src_q;
  logic [7:0]       wdt_ctl_q;
  logic             code_sel_q;
  logic             bus_w_q;

  // power-on reset looks like an external reset held low
  rcu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (ext_n_sync)
  );

  assign ext_req = ~ext_n_sync;

  always_comb begin
    req          = '0;
    req[SRC_EXT] = ext_req;
    req[SRC_WDT] = wdt_trip_i;
    req[SRC_SW]  = sw_rst_i;
  end

  rcu_prio i_prio (
    .req_i   (req),
    .valid_o (req_any),
    .onehot_o(req_onehot)
  );

  rcu_stretch #(.HOLD_CYC(HOLD_CYC)) i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_any),
    .active_o(rst_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_req_q <= 1'b1;
    else         ext_req_q <= ext_req;
  end

  assign strap_cap = ext_req_q & ~ext_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q     <= SRC_N'(1) << SRC_EXT;
      wdt_ctl_q <= WDT_CTL_AFTER_OTHER;
    end else if (req_any) begin
      src_q     <= req_onehot;
      wdt_ctl_q <= req_onehot[SRC_WDT] ? WDT_CTL_AFTER_WDT : WDT_CTL_AFTER_OTHER;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_sel_q <= 1'b1;
      bus_w_q    <= 1'b1;
    end else if (strap_cap) begin
      code_sel_q <= code_sel_wait_i;
      bus_w_q    <= bus_width_i;
    end
  end

  assign chip_rst_no     = ~rst_active;
  assign rst_src_o       = src_q;
  assign wdt_ctl_o       = wdt_ctl_q;
  assign bus_cfg_o       = {BUS_CFG_HI, bus_w_q, BUS_CFG_LO};
  assign code_ext_only_o = ~code_sel_q;
  assign wait_o          = code_sel_wait_i & ~rst_active;
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_req_i,
  input logic       wdt_trip_i,
  input logic       sw_rst_i,
  input logic       chip_rst_no,
  input logic [2:0] rst_src_o,
  input logic [7:0] wdt_ctl_o,
  input logic [7:0] bus_cfg_o
);
  assert_onehot_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rst_src_o) == 1);

  assert_wdt_asserts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_trip_i |=> !chip_rst_no);

  assert_sw_asserts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !chip_rst_no);

  assert_ext_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i |=> rst_src_o == 3'b001);

  assert_wdt_over_sw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_trip_i && !ext_req_i) |=> rst_src_o == 3'b010);

  assert_wdt_ctl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_trip_i && !ext_req_i) |=> wdt_ctl_o == 8'hE6);

  assert_release_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_rst_no) |-> $past(!ext_req_i && !wdt_trip_i && !sw_rst_i));

  assert_strap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rst_no && $past(chip_rst_no)) |-> $stable(bus_cfg_o));
endmodule

bind rst_cause_unit rcu_checker i_rcu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_req_i  (ext_req),
  .wdt_trip_i (wdt_trip_i),
  .sw_rst_i   (sw_rst_i),
  .chip_rst_no(chip_rst_no),
  .rst_src_o  (rst_src_o),
  .wdt_ctl_o  (wdt_ctl_o),
  .bus_cfg_o  (bus_cfg_o)
);

// File: tb/test_rst_cause_unit.sv
module test_rst_cause_unit;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic       wdt_trip_i = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       code_pin = 1'b0;
  logic       bw_pin = 1'b0;
  logic       chip_rst_no;
  logic [2:0] rst_src_o;
  logic [7:0] wdt_ctl_o;
  logic [7:0] bus_cfg_o;
  logic       code_ext_only_o;
  logic       wait_o;

  int checks = 0;
  int failures = 0;
  logic exp_code;
  logic exp_bw;

  always #2 clk = ~clk;

  rst_cause_unit #(.HOLD_CYC(HOLD), .SYNC_STAGES(2)) i_rst_cause_unit (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .ext_rst_ni     (ext_rst_ni),
    .wdt_trip_i     (wdt_trip_i),
    .sw_rst_i       (sw_rst_i),
    .code_sel_wait_i(code_pin),
    .bus_width_i    (bw_pin),
    .chip_rst_no    (chip_rst_no),
    .rst_src_o      (rst_src_o),
    .wdt_ctl_o      (wdt_ctl_o),
    .bus_cfg_o      (bus_cfg_o),
    .code_ext_only_o(code_ext_only_o),
    .wait_o         (wait_o)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bus_exp(logic a);
    return {5'b0, a, 2'b11};
  endfunction

  task automatic check_straps(string req);
    check({req, " bus_cfg"}, bus_cfg_o, bus_exp(exp_bw));
    check({req, " code_ext_only"}, {7'b0, code_ext_only_o}, {7'b0, ~exp_code});
  endtask

  task automatic ext_reset(logic code, logic bw);
    code_pin = code;
    bw_pin = bw;
    ext_rst_ni = 1'b0;
    tick(2);
    check("R1 ext not yet", {7'b0, chip_rst_no}, 8'h01);
    tick(1);
    check("R1 ext asserted", {7'b0, chip_rst_no}, 8'h00);
    tick(4);
    ext_rst_ni = 1'b1;
    tick(HOLD + 1);
    check("R2 ext still held", {7'b0, chip_rst_no}, 8'h00);
    tick(1);
    check("R2 ext released", {7'b0, chip_rst_no}, 8'h01);
    exp_code = code;
    exp_bw = bw;
    check("R3 src ext", {5'b0, rst_src_o}, 8'h01);
    check("R5 wdt_ctl ext", wdt_ctl_o, 8'hE4);
    check_straps("R6 R7 ext capture");
    code_pin = ~code;
    bw_pin = ~bw;
    tick(5);
    check_straps("R8 pins moved in run");
    code_pin = 1'b1;
    tick(1);
    check("R9 wait high", {7'b0, wait_o}, 8'h01);
    code_pin = 1'b0;
    tick(1);
    check("R9 wait low", {7'b0, wait_o}, 8'h00);
  endtask

  task automatic pulse_reset(logic wdt, logic sw);
    logic [7:0] src_e;
    src_e = wdt ? 8'h02 : 8'h04;
    code_pin = ~exp_code;
    bw_pin = ~exp_bw;
    wdt_trip_i = wdt;
    sw_rst_i = sw;
    tick(1);
    wdt_trip_i = 1'b0;
    sw_rst_i = 1'b0;
    check("R1 pulse asserted", {7'b0, chip_rst_no}, 8'h00);
    code_pin = 1'b1;
    tick(HOLD - 1);
    check("R2 pulse still held", {7'b0, chip_rst_no}, 8'h00);
    check("R9 wait masked in reset", {7'b0, wait_o}, 8'h00);
    tick(1);
    check("R2 pulse released", {7'b0, chip_rst_no}, 8'h01);
    check("R3 R4 src pulse", {5'b0, rst_src_o}, src_e);
    check("R5 wdt_ctl pulse", wdt_ctl_o, wdt ? 8'hE6 : 8'hE4);
    check_straps("R8 straps kept over pulse reset");
    tick(3);
    check("R3 src kept", {5'b0, rst_src_o}, src_e);
  endtask

  task automatic overlap_ext(logic wdt, logic sw);
    ext_rst_ni = 1'b0;
    tick(3);
    wdt_trip_i = wdt;
    sw_rst_i = sw;
    tick(1);
    wdt_trip_i = 1'b0;
    sw_rst_i = 1'b0;
    check("R4 ext beats others", {5'b0, rst_src_o}, 8'h01);
    check("R5 wdt_ctl under ext", wdt_ctl_o, 8'hE4);
    ext_rst_ni = 1'b1;
    tick(HOLD + 2);
    check("R2 overlap released", {7'b0, chip_rst_no}, 8'h01);
    exp_code = code_pin;
    exp_bw = bw_pin;
    check_straps("R6 R7 overlap capture");
  endtask

  initial begin
    code_pin = 1'b0;
    bw_pin = 1'b0;
    #10;
    check("R10 por chip_rst", {7'b0, chip_rst_no}, 8'h00);
    check("R10 por src", {5'b0, rst_src_o}, 8'h01);
    check("R10 por wdt_ctl", wdt_ctl_o, 8'hE4);
    check("R10 por bus_cfg", bus_cfg_o, 8'h07);
    check("R10 por code_ext_only", {7'b0, code_ext_only_o}, 8'h00);
    @(posedge clk);
    #1;
    rst_ni = 1'b1;
    tick(HOLD + 4);
    exp_code = 1'b0;
    exp_bw = 1'b0;
    check("R10 por released", {7'b0, chip_rst_no}, 8'h01);
    check_straps("R10 por capture");

    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 2; b++) begin
        ext_reset(c[0], b[0]);
        pulse_reset(1'b1, 1'b0);
        pulse_reset(1'b0, 1'b1);
        pulse_reset(1'b1, 1'b1);
      end
    end
    for (int m = 1; m < 4; m++) begin
      code_pin = m[0];
      bw_pin = m[1];
      overlap_ext(m[0], m[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule